// File: doc/BRIEF.md
# Link Controller Power-State and Wake Logic

This block keeps the power state of the two functions of an audio/modem serial-link controller, audio and modem, each either fully on (D0) or suspended (D3). It watches the serial data input lines from the codecs and a GPIO change pulse for resume signalling. It routes each resume event either into a per-source interrupt status bit, while the owning function is on, or into a shared wake status bit that drives the PME output. The enabled status bits are merged into one level interrupt. Bits that belong to a suspended function are kept off that interrupt.

Configuration logic writes the power states, the interrupt enables and the PME enables through plain write strobes. It clears status bits by writing ones. It asks the block whether a memory or I/O access to a function has to be master-aborted. A write that brings a function from D3 back to D0 produces a one-cycle reset for that function. Each resume line goes through a two-flop synchronizer and an edge detector. A line that was raised while a function slept therefore does not raise a stale interrupt once the function wakes.

Top module: `pm_wake_ctl`

## Requirements
- R1: Each function has a power state written through `pst_wr[f]` (f=0 audio, f=1 modem) with `pst_data` 2'b00 = D0 and 2'b11 = D3. Both functions reset to D0. A write of 2'b01 or 2'b10 is ignored. `fn_d3[f]` shows the state.
- R2: `acc_abort` is high in the same cycle as `acc_req` when the function picked by `acc_fn` (0 audio, 1 modem) is in D3, and low otherwise.
- R3: `irq` is the OR of `int_sts & int_en` over the bits whose owning function is in D0. No bit that belongs to a function in D3 can raise `irq`.
- R4: A legal write of D0 to a function that is in D3 pulses `fn_rst[f]` for exactly the one cycle after the write edge. No other write produces a pulse.
- R5: That internal reset clears the interrupt status bits and interrupt enable bits owned by the function, and it wins over a same-cycle write. It keeps the PME enables and the wake status.
- R6: A resume event on line i sets `wake_sts` when the PME enable of the line's owner is set (`pme_en` bit 0 audio, bit 1 modem). `pme_o` follows `wake_sts`. `wake_clr` clears it by writing one.
- R7: A `gpio_chg` pulse sets interrupt status bit NUM_LINES while the modem is in D0. It sets `wake_sts` only while the modem is in D3 with its PME enable set, and never while the modem is in D0.
- R8: A resume event on line i sets `int_sts[i]` only while the line's owner is in D0. Lines flagged in MODEM_LINES belong to the modem and the rest belong to audio. Bit NUM_LINES (GPIO) belongs to the modem.
- R9: A resume event is a rising edge of `sdin` after a two-flop synchronizer and is counted once per edge. Its status is visible after the third rising clock edge following the input change. A line held high across a D3-to-D0 move raises no new status.
- R10: `int_sts` bits are cleared by writing one to `sts_clr`. When a clear and a new event hit the same bit in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pst_wr | input | 2 | Power-state write strobe per function |
| pst_data | input | 2 | Power-state write value (00 D0, 11 D3) |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_in | input | NUM_LINES+1 | Interrupt enable write value |
| pme_en_wr | input | 1 | PME enable write strobe |
| pme_en_in | input | 2 | PME enable write value per function |
| sts_clr | input | NUM_LINES+1 | Write-one-to-clear for interrupt status |
| wake_clr | input | 1 | Write-one-to-clear for wake status |
| acc_req | input | 1 | Memory/I/O access request |
| acc_fn | input | 1 | Target function of the access |
| sdin | input | NUM_LINES | Serial data input lines (resume signalling) |
| gpio_chg | input | 1 | Synchronous GPIO status-change pulse |
| fn_d3 | output | 2 | Function in D3 |
| fn_rst | output | 2 | One-cycle internal reset per function |
| acc_abort | output | 1 | Access must be master-aborted |
| int_sts | output | NUM_LINES+1 | Interrupt status (lines, then GPIO) |
| int_en | output | NUM_LINES+1 | Interrupt enables |
| pme_en | output | 2 | PME enables |
| wake_sts | output | 1 | Shared wake status |
| pme_o | output | 1 | Wake request output |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with three resume lines and MODEM_LINES = 4, so line 2 belongs to the modem and lines 0 and 1 to audio. With both owners present, one random run reaches the two gating paths at once: one function can sleep while the other takes interrupts, and a D3-to-D0 reset clears only its own bits. The narrow line count lets random toggling and sparse GPIO pulses reach same-cycle clear-and-set collisions and wakes with a line already held high.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

  localparam int FN_AUD = 0;
  localparam int FN_MDM = 1;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D3 = 2'b11
  } pstate_e;

  function automatic logic ps_code_legal(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3);
  endfunction

  // pick the per-function flag belonging to the owner of a source
  function automatic logic owner_flag(input logic is_modem, input logic [1:0] per_fn);
    return is_modem ? per_fn[FN_MDM] : per_fn[FN_AUD];
  endfunction

  function automatic logic w1c_bit(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/pm_rsm_detect.sv
module pm_rsm_detect #(
  parameter int NUM_LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] rise_evt
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= line_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_evt[i] = sync_q & ~prev_q;

    assert_one_evt_per_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt[i] |=> !rise_evt[i]);
  end

endmodule

// File: rtl/pm_fn_state.sv
module pm_fn_state
  import pm_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       in_d3,
  output logic       rst_req,
  output logic       rst_pulse
);

  pstate_e state_q;
  logic    wr_ok;

  assign wr_ok   = wr && ps_code_legal(wdata);
  assign rst_req = wr_ok && (wdata == PS_D0) && (state_q == PS_D3);
  assign in_d3   = (state_q == PS_D3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_D0;
      rst_pulse <= 1'b0;
    end else begin
      if (wr_ok) state_q <= pstate_e'(wdata);
      rst_pulse <= rst_req;
    end
  end

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_D0) || (state_q == PS_D3));

  assert_rst_after_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (!in_d3 && $past(in_d3)));

  assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

endmodule

// File: rtl/pm_sts_regs.sv
module pm_sts_regs
  import pm_wake_pkg::*;
#(
  parameter int          NUM_LINES   = 3,
  parameter int unsigned MODEM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] rise_evt,
  input  logic                 gpio_chg,
  input  logic [1:0]           fn_d3,
  input  logic [1:0]           fn_rst_req,
  input  logic                 ien_wr,
  input  logic [NUM_LINES:0]   ien_in,
  input  logic [NUM_LINES:0]   sts_clr,
  input  logic                 pme_en_wr,
  input  logic [1:0]           pme_en_in,
  input  logic                 wake_clr,
  output logic [NUM_LINES:0]   sts_q,
  output logic [NUM_LINES:0]   ien_q,
  output logic [1:0]           pme_en_q,
  output logic                 wake_q,
  output logic                 irq
);

  localparam int NB = NUM_LINES + 1;
  localparam logic [NUM_LINES-1:0] LINE_MDM = MODEM_LINES[NUM_LINES-1:0];
  localparam logic [NB-1:0]        OWN_MDM  = {1'b1, LINE_MDM};

  logic [NB-1:0] owner_asleep;
  logic [NB-1:0] owner_reset;
  logic [NB-1:0] sts_set;
  logic [NB-1:0] line_wake;
  logic          gpio_wake;
  logic          wake_set;
  logic [NB-1:0] irq_src;

  for (genvar b = 0; b < NB; b++) begin : g_own
    assign owner_asleep[b] = owner_flag(OWN_MDM[b], fn_d3);
    assign owner_reset[b]  = owner_flag(OWN_MDM[b], fn_rst_req);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_set
    assign sts_set[i]   = rise_evt[i] && !owner_asleep[i];
    assign line_wake[i] = rise_evt[i] && owner_flag(OWN_MDM[i], pme_en_q);
  end
  assign sts_set[NUM_LINES]   = gpio_chg && !fn_d3[FN_MDM];
  assign line_wake[NUM_LINES] = 1'b0;

  assign gpio_wake = gpio_chg && fn_d3[FN_MDM] && pme_en_q[FN_MDM];
  assign wake_set  = (|line_wake) || gpio_wake;

  assign irq_src = sts_q & ien_q & ~owner_asleep;
  assign irq     = |irq_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      ien_q    <= '0;
      pme_en_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (owner_reset[b]) begin
          sts_q[b] <= 1'b0;
          ien_q[b] <= 1'b0;
        end else begin
          sts_q[b] <= w1c_bit(sts_q[b], sts_set[b], sts_clr[b]);
          if (ien_wr) ien_q[b] <= ien_in[b];
        end
      end
      if (pme_en_wr) pme_en_q <= pme_en_in;
      wake_q <= w1c_bit(wake_q, wake_set, wake_clr);
    end
  end

  assert_irq_quiet_all_d3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&fn_d3) |-> !irq);

  assert_wake_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(|pme_en_q));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    assert_no_set_while_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[i]) |-> $past(!owner_asleep[i]));
  end

  assert_gpio_no_wake_d0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_chg && !fn_d3[FN_MDM] && !(|rise_evt) && !wake_q) |=> !wake_q);

endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
  import pm_wake_pkg::*;
#(
  parameter int          NUM_LINES   = 3,
  parameter int unsigned MODEM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pst_wr,
  input  logic [1:0]           pst_data,
  input  logic                 ien_wr,
  input  logic [NUM_LINES:0]   ien_in,
  input  logic                 pme_en_wr,
  input  logic [1:0]           pme_en_in,
  input  logic [NUM_LINES:0]   sts_clr,
  input  logic                 wake_clr,
  input  logic                 acc_req,
  input  logic                 acc_fn,
  input  logic [NUM_LINES-1:0] sdin,
  input  logic                 gpio_chg,
  output logic [1:0]           fn_d3,
  output logic [1:0]           fn_rst,
  output logic                 acc_abort,
  output logic [NUM_LINES:0]   int_sts,
  output logic [NUM_LINES:0]   int_en,
  output logic [1:0]           pme_en,
  output logic                 wake_sts,
  output logic                 pme_o,
  output logic                 irq
);

  logic [NUM_LINES-1:0] rise_evt;
  logic [1:0]           fn_rst_req;

  pm_rsm_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (sdin),
    .rise_evt (rise_evt)
  );

  for (genvar f = 0; f < 2; f++) begin : g_fn
    pm_fn_state u_fn (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (pst_wr[f]),
      .wdata     (pst_data),
      .in_d3     (fn_d3[f]),
      .rst_req   (fn_rst_req[f]),
      .rst_pulse (fn_rst[f])
    );
  end

  pm_sts_regs #(.NUM_LINES(NUM_LINES), .MODEM_LINES(MODEM_LINES)) u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt   (rise_evt),
    .gpio_chg   (gpio_chg),
    .fn_d3      (fn_d3),
    .fn_rst_req (fn_rst_req),
    .ien_wr     (ien_wr),
    .ien_in     (ien_in),
    .sts_clr    (sts_clr),
    .pme_en_wr  (pme_en_wr),
    .pme_en_in  (pme_en_in),
    .wake_clr   (wake_clr),
    .sts_q      (int_sts),
    .ien_q      (int_en),
    .pme_en_q   (pme_en),
    .wake_q     (wake_sts),
    .irq        (irq)
  );

  assign acc_abort = acc_req && (acc_fn ? fn_d3[FN_MDM] : fn_d3[FN_AUD]);
  assign pme_o     = wake_sts;

  assert_abort_only_d3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |-> (fn_d3 != 2'b00));

  assert_reset_keeps_pme_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fn_rst && !$past(pme_en_wr)) |-> $stable(pme_en));

endmodule

// File: tb/pm_wake_ctl_bench.sv
`timescale 1ns/1ps
module pm_wake_ctl_bench;

  localparam int NL = 3;
  localparam logic [NL:0] OWN_M = 4'b1100; // gpio bit 3 and line 2 belong to modem

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  pst_wr = '0, pst_data = '0;
  logic        ien_wr = 0, pme_en_wr = 0, wake_clr = 0, acc_req = 0, acc_fn = 0, gpio_chg = 0;
  logic [NL:0] ien_in = '0, sts_clr = '0;
  logic [1:0]  pme_en_in = '0;
  logic [NL-1:0] sdin = '0;

  logic [1:0]  fn_d3, fn_rst, pme_en;
  logic        acc_abort, wake_sts, pme_o, irq;
  logic [NL:0] int_sts, int_en;

  pm_wake_ctl #(.NUM_LINES(NL), .MODEM_LINES(4)) u_pm_wake_ctl (
    .clk(clk), .rst_n(rst_n), .pst_wr(pst_wr), .pst_data(pst_data),
    .ien_wr(ien_wr), .ien_in(ien_in), .pme_en_wr(pme_en_wr), .pme_en_in(pme_en_in),
    .sts_clr(sts_clr), .wake_clr(wake_clr), .acc_req(acc_req), .acc_fn(acc_fn),
    .sdin(sdin), .gpio_chg(gpio_chg), .fn_d3(fn_d3), .fn_rst(fn_rst),
    .acc_abort(acc_abort), .int_sts(int_sts), .int_en(int_en), .pme_en(pme_en),
    .wake_sts(wake_sts), .pme_o(pme_o), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // expected-state model built from the requirements
  logic [1:0]    m_d3, m_rst, m_pme;
  logic [NL:0]   m_sts, m_ien;
  logic          m_wake;
  logic [NL-1:0] m_s1, m_s2, m_s3;

  function automatic logic asleep_of(input int b, input logic [1:0] d3);
    return OWN_M[b] ? d3[1] : d3[0];
  endfunction

  function automatic logic [NL:0] irq_mask(input logic [1:0] d3);
    logic [NL:0] m;
    for (int b = 0; b <= NL; b++) m[b] = !asleep_of(b, d3);
    return m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d3 = 0; m_rst = 0; m_pme = 0; m_sts = 0; m_ien = 0; m_wake = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic [NL-1:0] ev;
      logic [1:0] od3, rq;
      logic [NL:0] st;
      logic wk;
      ev = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sdin;
      od3 = m_d3;
      for (int f = 0; f < 2; f++) begin
        rq[f] = pst_wr[f] && pst_data == 2'b00 && od3[f];
        if (pst_wr[f] && (pst_data == 2'b00 || pst_data == 2'b11)) m_d3[f] = pst_data[0];
      end
      wk = gpio_chg && od3[1] && m_pme[1];
      for (int i = 0; i < NL; i++) begin
        st[i] = ev[i] && !asleep_of(i, od3);
        if (ev[i] && (OWN_M[i] ? m_pme[1] : m_pme[0])) wk = 1;
      end
      st[NL] = gpio_chg && !od3[1];
      m_sts = (m_sts & ~sts_clr) | st;
      if (ien_wr) m_ien = ien_in;
      for (int b = 0; b <= NL; b++)
        if (OWN_M[b] ? rq[1] : rq[0]) begin m_sts[b] = 0; m_ien[b] = 0; end
      m_wake = (m_wake & ~wake_clr) | wk;
      if (pme_en_wr) m_pme = pme_en_in;
      m_rst = rq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R1 fn_d3", 32'(fn_d3), 32'(m_d3));
    chk("R4 fn_rst", 32'(fn_rst), 32'(m_rst));
    chk("R8 int_sts", 32'(int_sts), 32'(m_sts));
    chk("R5 int_en", 32'(int_en), 32'(m_ien));
    chk("R5 pme_en", 32'(pme_en), 32'(m_pme));
    chk("R6 wake_sts", 32'(wake_sts), 32'(m_wake));
    chk("R6 pme_o", 32'(pme_o), 32'(m_wake));
    chk("R3 irq", 32'(irq), 32'(|(m_sts & m_ien & irq_mask(m_d3))));
    chk("R2 acc_abort", 32'(acc_abort), 32'(acc_req && m_d3[acc_fn]));
  endtask

  task automatic idle();
    pst_wr = 0; ien_wr = 0; pme_en_wr = 0; sts_clr = 0; wake_clr = 0; gpio_chg = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compare_all();
    idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state D0", 32'(fn_d3), 32'd0);
    chk("R8 reset status", 32'(int_sts), 32'd0);
    chk("R6 reset wake", 32'(wake_sts), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: illegal codes ignored
    pst_wr = 2'b11; pst_data = 2'b01; step();
    chk("R1 illegal code ignored", 32'(fn_d3), 32'd0);

    // R8/R9: line 0 edge with audio in D0, visible after third edge
    ien_wr = 1; ien_in = 4'b1111; step();
    sdin = 3'b001;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 not yet after two edges", 32'(int_sts[0]), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 status after third edge", 32'(int_sts[0]), 32'd1);
    chk("R3 irq from enabled D0 bit", 32'(irq), 32'd1);
    sdin = 3'b000;
    sts_clr = 4'b0001; step();
    chk("R10 cleared by one", 32'(int_sts[0]), 32'd0);

    // R6/R9: modem sleeps, line 2 raised and held, wakes; no stale interrupt
    pme_en_wr = 1; pme_en_in = 2'b10; step();
    pst_wr = 2'b10; pst_data = 2'b11; step();
    acc_req = 1; acc_fn = 1; step();
    chk("R2 abort to D3 modem", 32'(acc_abort), 32'd1);
    acc_req = 0;
    sdin = 3'b100; repeat (4) step();
    chk("R6 wake set", 32'(wake_sts), 32'd1);
    chk("R8 no status while D3", 32'(int_sts[2]), 32'd0);
    pst_wr = 2'b10; pst_data = 2'b00; step();
    chk("R4 reset pulse", 32'(fn_rst), 32'b10);
    step();
    chk("R4 pulse one cycle", 32'(fn_rst), 32'd0);
    chk("R5 wake kept", 32'(wake_sts), 32'd1);
    chk("R5 modem enables cleared", 32'(int_en), 32'b0011);
    repeat (4) step();
    chk("R9 held line no stale status", 32'(int_sts[2]), 32'd0);
    sdin = 3'b000; wake_clr = 1; step();

    // R7: gpio in D0 sets status, no wake
    gpio_chg = 1; step();
    chk("R7 gpio status in D0", 32'(int_sts[3]), 32'd1);
    chk("R7 gpio no wake in D0", 32'(wake_sts), 32'd0);

    // random phase, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) begin pst_wr = 2'($urandom); pst_data = 2'($urandom); end
      if (r[7:4] == 0) begin ien_wr = 1; ien_in = 4'($urandom); end
      if (r[11:8] == 0) begin pme_en_wr = 1; pme_en_in = 2'($urandom); end
      if (r[14:12] == 0) sts_clr = 4'($urandom);
      if (r[18:15] == 0) wake_clr = 1;
      if (r[21:19] == 0) sdin[r[23:22] % NL] = ~sdin[r[23:22] % NL];
      if (r[26:24] == 0) gpio_chg = 1;
      acc_req = r[27]; acc_fn = r[28];
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule